// File: doc/BRIEF.md
# Window Alarm Scan Controller

This block paces a repeating series of conversions over up to four input channels and watches each result against a programmable window. A free-running divider produces a conversion-start pulse. The pulse carries the channel to convert, and the channel advances round-robin from 0 up to the last configured channel. When the converter reports a result, the block compares it with that channel's lower and upper thresholds. A result outside the window latches a sticky alarm bit for that channel.

A single configuration byte, written with a one-cycle strobe, does three things:
- It sets the scan rate with a 3-bit code. Each step of the code halves the rate.
- It enables or disables the interrupt.
- It clears selected alarms through write-one-to-clear bits.

The interrupt is an active-low open-drain style output, modelled as a low-drive enable. It is driven only while it is enabled, some alarm is latched and no alert acknowledge has been received for the current alarms. The alarm bits are always visible, whatever the state of the interrupt.

Top module: `wscan_top`

## Requirements
- R1: After reset, every alarm bit is 0, the interrupt low-drive is 0, the rate code is 0 and the interrupt enable is 0.
- R2: A conversion-done result strictly below the lower threshold of its channel sets that channel's alarm in the following cycle; a result equal to the lower threshold does not set it.
- R3: A conversion-done result strictly above the upper threshold of its channel sets that channel's alarm in the following cycle; a result equal to the upper threshold does not set it.
- R4: A set alarm stays set until a configuration write clears it; in-window results do not clear it.
- R5: On a configuration write, byte bit 7 clears the alarm of channel 0, bit 6 clears channel 1, bit 5 clears channel 2 and bit 4 clears channel 3; a 0 in any of these bits leaves that alarm unchanged.
- R6: If a clearing write and a new out-of-window result on the same channel arrive in the same cycle, the alarm of that channel ends up set.
- R7: Configuration bits 3..1 form the rate code (bit 3 is the MSB). In steady state, consecutive conversion-start pulses are BASE_DIV * 2^code clock cycles apart, and each pulse lasts one cycle.
- R8: The channel carried by successive start pulses steps 0, 1, ... up to the last-channel input and then wraps to 0.
- R9: Configuration bit 0 is the interrupt enable. The low-drive output is 1 only when the enable is 1 and at least one alarm is set. With the enable at 0, it is 0 even when alarms are set.
- R10: An alert acknowledge while an alarm is set forces the low-drive output to 0 from the next cycle and leaves the alarm bits unchanged. A later newly set alarm drives it again. An acknowledge with no alarm set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle strobe that writes cfg_byte |
| cfg_byte | input | 8 | Clear bits [7:4], rate code [3:1], interrupt enable [0] |
| last_ch | input | 2 | Highest channel included in the scan |
| lo_thr | input | 40 | Lower thresholds, channel i in bits [10i+9:10i] |
| hi_thr | input | 40 | Upper thresholds, channel i in bits [10i+9:10i] |
| conv_done | input | 1 | Conversion result valid strobe |
| conv_res | input | 10 | Conversion result |
| conv_ch | input | 2 | Channel of the conversion result |
| alert_ack | input | 1 | Alert acknowledge event |
| conv_start | output | 1 | Conversion start pulse |
| conv_start_ch | output | 2 | Channel to convert with the start pulse |
| alarm | output | 4 | Latched alarm bits, bit i for channel i |
| int_drive_low | output | 1 | Interrupt active: pin pulled low |

## Verification
The assertions assume that cfg_wr, conv_done and alert_ack are one-cycle strobes sampled on the rising edge. They also assume that the thresholds and conv_ch are steady during a conversion-done cycle, and that BASE_DIV is at least 2, so that start pulses can never occur back to back. The stimulus drives every input on the falling edge and holds the thresholds constant. It raises each strobe for exactly one cycle and keeps last_ch fixed while the channel sequence is recorded.

// File: rtl/wscan_pkg.sv
package wscan_pkg;

    localparam int CFG_W    = 8;
    localparam int CLR_W    = 4;
    localparam int CODE_W   = 3;

    typedef struct packed {
        logic [CLR_W-1:0]  clr;     // clr[i] clears channel i
        logic [CODE_W-1:0] code;
        logic              int_en;
    } cfg_t;

    // Byte MSB is the clear bit of channel 0, so the clear field is reversed.
    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] b);
        cfg_t c;
        for (int i = 0; i < CLR_W; i++) begin
            c.clr[i] = b[CFG_W-1-i];
        end
        c.code   = b[CODE_W:1];
        c.int_en = b[0];
        return c;
    endfunction

    function automatic logic outside_window(input logic [15:0] val,
                                            input logic [15:0] lo,
                                            input logic [15:0] hi);
        return (val < lo) || (val > hi);
    endfunction

endpackage

// File: rtl/wscan_rate.sv
module wscan_rate
    import wscan_pkg::*;
#(
    parameter int BASE_DIV = 4,
    parameter int NCH      = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CODE_W-1:0]        code,
    input  logic [$clog2(NCH)-1:0]   last_ch,
    output logic                     start,
    output logic [$clog2(NCH)-1:0]   start_ch
);
    localparam int BW     = $clog2(BASE_DIV);
    localparam int PCNT_W = (1 << CODE_W) - 1;
    localparam int CH_W   = $clog2(NCH);

    logic [BW-1:0]     bcnt;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W:0]   one_sh;
    logic [PCNT_W-1:0] mask;
    logic              tick;
    logic [CH_W-1:0]   idx;

    assign tick   = (bcnt == BW'(BASE_DIV - 1));
    assign one_sh = {{PCNT_W{1'b0}}, 1'b1} << code;
    assign mask   = one_sh[PCNT_W-1:0] - {{(PCNT_W-1){1'b0}}, 1'b1};
    assign start  = tick && ((pcnt & mask) == mask);
    assign start_ch = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt <= '0;
            pcnt <= '0;
            idx  <= '0;
        end else begin
            bcnt <= tick ? '0 : bcnt + 1'b1;
            if (tick) begin
                pcnt <= pcnt + 1'b1;
            end
            if (start) begin
                idx <= (idx >= last_ch) ? '0 : idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wscan_win.sv
module wscan_win
    import wscan_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0]       res,
    input  logic [$clog2(NCH)-1:0] ch,
    input  logic [NCH*RES_W-1:0]   lo_flat,
    input  logic [NCH*RES_W-1:0]   hi_flat,
    output logic                   outside
);
    logic [RES_W-1:0] lo_sel;
    logic [RES_W-1:0] hi_sel;

    assign lo_sel  = lo_flat[ch*RES_W +: RES_W];
    assign hi_sel  = hi_flat[ch*RES_W +: RES_W];
    assign outside = outside_window(16'(res), 16'(lo_sel), 16'(hi_sel));

endmodule

// File: rtl/wscan_alarm.sv
module wscan_alarm #(
    parameter int NCH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit,
    input  logic [$clog2(NCH)-1:0] hit_ch,
    input  logic                   clr_wr,
    input  logic [NCH-1:0]         clr_mask,
    input  logic                   alert_ack,
    input  logic                   int_en,
    output logic [NCH-1:0]         alarm,
    output logic                   int_act
);
    logic [NCH-1:0] set_vec;
    logic [NCH-1:0] alarm_nxt;
    logic           new_evt;
    logic           muted;
    logic           muted_nxt;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign set_vec[i]   = hit && (hit_ch == i);
        // a fresh hit outranks a clear in the same cycle
        assign alarm_nxt[i] = set_vec[i] | (alarm[i] & ~(clr_wr & clr_mask[i]));
    end

    assign new_evt = |(set_vec & ~alarm);

    always_comb begin
        muted_nxt = muted;
        if (new_evt) begin
            muted_nxt = 1'b0;
        end else if (alert_ack && (|alarm)) begin
            muted_nxt = 1'b1;
        end else if (~|alarm_nxt) begin
            muted_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= '0;
            muted <= 1'b0;
        end else begin
            alarm <= alarm_nxt;
            muted <= muted_nxt;
        end
    end

    assign int_act = int_en && (|alarm) && !muted;

endmodule

// File: rtl/wscan_top.sv
module wscan_top
    import wscan_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int RES_W    = 10,
    parameter int BASE_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [7:0]               cfg_byte,
    input  logic [$clog2(NCH)-1:0]   last_ch,
    input  logic [NCH*RES_W-1:0]     lo_thr,
    input  logic [NCH*RES_W-1:0]     hi_thr,
    input  logic                     conv_done,
    input  logic [RES_W-1:0]         conv_res,
    input  logic [$clog2(NCH)-1:0]   conv_ch,
    input  logic                     alert_ack,
    output logic                     conv_start,
    output logic [$clog2(NCH)-1:0]   conv_start_ch,
    output logic [NCH-1:0]           alarm,
    output logic                     int_drive_low
);
    cfg_t              cfg_in;
    logic [CODE_W-1:0] code_q;
    logic              int_en_q;
    logic              outside;

    assign cfg_in = decode_cfg(cfg_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            int_en_q <= 1'b0;
        end else if (cfg_wr) begin
            code_q   <= cfg_in.code;
            int_en_q <= cfg_in.int_en;
        end
    end

    wscan_rate #(.BASE_DIV(BASE_DIV), .NCH(NCH)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .code     (code_q),
        .last_ch  (last_ch),
        .start    (conv_start),
        .start_ch (conv_start_ch)
    );

    wscan_win #(.NCH(NCH), .RES_W(RES_W)) u_win (
        .res     (conv_res),
        .ch      (conv_ch),
        .lo_flat (lo_thr),
        .hi_flat (hi_thr),
        .outside (outside)
    );

    wscan_alarm #(.NCH(NCH)) u_alarm (
        .clk       (clk),
        .rst       (rst),
        .hit       (conv_done && outside),
        .hit_ch    (conv_ch),
        .clr_wr    (cfg_wr),
        .clr_mask  (cfg_in.clr[NCH-1:0]),
        .alert_ack (alert_ack),
        .int_en    (int_en_q),
        .alarm     (alarm),
        .int_act   (int_drive_low)
    );

endmodule

// File: rtl/wscan_chk.sv
module wscan_chk #(
    parameter int NCH   = 4,
    parameter int RES_W = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_wr,
    input logic [7:0]             cfg_byte,
    input logic [NCH*RES_W-1:0]   lo_thr,
    input logic [NCH*RES_W-1:0]   hi_thr,
    input logic                   conv_done,
    input logic [RES_W-1:0]       conv_res,
    input logic [$clog2(NCH)-1:0] conv_ch,
    input logic                   alert_ack,
    input logic                   conv_start,
    input logic [NCH-1:0]         alarm,
    input logic                   int_drive_low
);
    logic [RES_W-1:0] lo_sel;
    logic [RES_W-1:0] hi_sel;
    assign lo_sel = lo_thr[conv_ch*RES_W +: RES_W];
    assign hi_sel = hi_thr[conv_ch*RES_W +: RES_W];

    assert_below_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (conv_done && (conv_res < lo_sel)) |=> alarm[$past(conv_ch)]);

    assert_above_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (conv_done && (conv_res > hi_sel)) |=> alarm[$past(conv_ch)]);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ((alarm & $past(alarm)) == $past(alarm)));

    assert_clear_ch0_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_byte[7] && !conv_done) |=> !alarm[0]);

    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_int_needs_alarm_R9: assert property (@(posedge clk) disable iff (rst)
        int_drive_low |-> (alarm != '0));

    assert_ack_mutes_R10: assert property (@(posedge clk) disable iff (rst)
        (alert_ack && (alarm != '0) && !conv_done && !cfg_wr) |=> !int_drive_low);

endmodule

bind wscan_top wscan_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_byte      (cfg_byte),
    .lo_thr        (lo_thr),
    .hi_thr        (hi_thr),
    .conv_done     (conv_done),
    .conv_res      (conv_res),
    .conv_ch       (conv_ch),
    .alert_ack     (alert_ack),
    .conv_start    (conv_start),
    .alarm         (alarm),
    .int_drive_low (int_drive_low)
);

// File: tb/test_wscan_top.sv
module test_wscan_top;
    localparam int NCH = 4;
    localparam int RES_W = 10;
    localparam int BASE_DIV = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic [1:0] last_ch = 2'd3;
    logic [NCH*RES_W-1:0] lo_thr;
    logic [NCH*RES_W-1:0] hi_thr;
    logic conv_done = 1'b0;
    logic [RES_W-1:0] conv_res = '0;
    logic [1:0] conv_ch = '0;
    logic alert_ack = 1'b0;
    logic conv_start;
    logic [1:0] conv_start_ch;
    logic [NCH-1:0] alarm;
    logic int_drive_low;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // ch0 100..200, ch1 300..400, ch2 500..600, ch3 10..1000
    assign lo_thr = {10'd10, 10'd500, 10'd300, 10'd100};
    assign hi_thr = {10'd1000, 10'd600, 10'd400, 10'd200};

    wscan_top #(.NCH(NCH), .RES_W(RES_W), .BASE_DIV(BASE_DIV)) i_wscan_top (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .last_ch(last_ch), .lo_thr(lo_thr), .hi_thr(hi_thr),
        .conv_done(conv_done), .conv_res(conv_res), .conv_ch(conv_ch),
        .alert_ack(alert_ack), .conv_start(conv_start),
        .conv_start_ch(conv_start_ch), .alarm(alarm),
        .int_drive_low(int_drive_low));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic [3:0] clr, input logic [2:0] code,
                                      input logic en);
        return {clr[0], clr[1], clr[2], clr[3], code, en};
    endfunction

    task automatic wr_cfg(input logic [7:0] b);
        @(negedge clk); cfg_wr = 1'b1; cfg_byte = b;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic conv(input logic [1:0] ch, input int res);
        @(negedge clk); conv_done = 1'b1; conv_ch = ch; conv_res = RES_W'(res);
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); alert_ack = 1'b1;
        @(negedge clk); alert_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 alarm after reset", alarm, 0);
        chk("R1 int after reset", int_drive_low, 0);
        conv(2'd0, 50);
        chk("R1 enable off: int stays idle", int_drive_low, 0);
        wr_cfg(mk(4'hF, 3'd0, 1'b0));
        chk("R1 cleared", alarm, 0);
    endtask

    task automatic t_low();
        conv(2'd0, 100);
        chk("R2 equal to lower: no alarm", alarm, 0);
        conv(2'd1, 299);
        chk("R2 below lower on ch1", alarm, 4'b0010);
        wr_cfg(mk(4'hF, 3'd0, 1'b0));
    endtask

    task automatic t_high();
        conv(2'd2, 600);
        chk("R3 equal to upper: no alarm", alarm, 0);
        conv(2'd3, 1001);
        chk("R3 above upper on ch3", alarm, 4'b1000);
    endtask

    task automatic t_sticky();
        conv(2'd3, 500);
        chk("R4 in-window keeps alarm", alarm, 4'b1000);
        repeat (5) @(negedge clk);
        chk("R4 alarm held", alarm, 4'b1000);
    endtask

    task automatic t_clear();
        conv(2'd0, 5); conv(2'd1, 5); conv(2'd2, 5);
        chk("R5 all set", alarm, 4'b1111);
        wr_cfg(mk(4'b0000, 3'd0, 1'b0));
        chk("R5 zero bits no effect", alarm, 4'b1111);
        wr_cfg(mk(4'b0100, 3'd0, 1'b0));
        chk("R5 clear ch2 via bit5", alarm, 4'b1011);
        wr_cfg(mk(4'b0001, 3'd0, 1'b0));
        chk("R5 clear ch0 via bit7", alarm, 4'b1010);
        wr_cfg(mk(4'b1010, 3'd0, 1'b0));
        chk("R5 clear ch1,ch3", alarm, 4'b0000);
    endtask

    task automatic t_collide();
        conv(2'd1, 5);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_byte = mk(4'b0110, 3'd0, 1'b0);
        conv_done = 1'b1; conv_ch = 2'd2; conv_res = 10'd700;
        @(negedge clk);
        cfg_wr = 1'b0; conv_done = 1'b0;
        chk("R6 new alarm wins over clear", alarm, 4'b0100);
        wr_cfg(mk(4'hF, 3'd0, 1'b0));
    endtask

    task automatic measure(input logic [2:0] code);
        int gap;
        wr_cfg(mk(4'h0, code, 1'b0));
        for (int k = 0; k < 2; k++) begin
            do @(negedge clk); while (!conv_start);
        end
        gap = 0;
        do begin @(negedge clk); gap++; end while (!conv_start);
        chk($sformatf("R7 start gap code %0d", code), gap, BASE_DIV << code);
        @(negedge clk);
        chk("R7 single-cycle pulse", conv_start, 0);
    endtask

    task automatic t_rate();
        measure(3'd0); measure(3'd1); measure(3'd3); measure(3'd7);
        wr_cfg(mk(4'h0, 3'd0, 1'b0));
    endtask

    task automatic t_rr();
        int prev;
        last_ch = 2'd2;
        repeat (2) begin
            do @(negedge clk); while (!conv_start);
        end
        prev = conv_start_ch;
        for (int k = 0; k < 7; k++) begin
            do @(negedge clk); while (!conv_start);
            chk("R8 round-robin step", conv_start_ch, (prev == 2) ? 0 : prev + 1);
            prev = conv_start_ch;
        end
        last_ch = 2'd3;
    endtask

    task automatic t_int();
        conv(2'd0, 5);
        chk("R9 enable off", int_drive_low, 0);
        wr_cfg(mk(4'h0, 3'd0, 1'b1));
        chk("R9 enabled with alarm", int_drive_low, 1);
        wr_cfg(mk(4'b0001, 3'd0, 1'b1));
        chk("R9 no alarm no int", int_drive_low, 0);
    endtask

    task automatic t_ack();
        ack();
        conv(2'd1, 5);
        chk("R10 ack without alarm ignored", int_drive_low, 1);
        ack();
        chk("R10 ack mutes int", int_drive_low, 0);
        chk("R10 alarm kept after ack", alarm, 4'b0010);
        conv(2'd3, 1020);
        chk("R10 new alarm rearms", int_drive_low, 1);
        wr_cfg(mk(4'hF, 3'd0, 1'b1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_low();
        t_high();
        t_sticky();
        t_clear();
        t_collide();
        t_rate();
        t_rr();
        t_int();
        t_ack();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule